// File: doc/BRIEF.md
# SDRAM Clock-Suspend and Low-Power Controller

This block owns the clock-enable pin of an SDRAM and the command pins for every command that must coincide with a CKE transition. It accepts three kinds of request. The first is a short clock suspension during a burst that is in flight. The second is power-down while no burst runs. The third is self-refresh, which holds for as long as its request stays high. It picks the right low-power state from the per-bank open flags. While the device clock is masked it raises a freeze output, so the burst engine holds its column position and data capture. The burst is then extended by exactly the number of masked cycles.

Ordinary commands from the upstream sequencer pass through a valid/ready pair and appear on the pins one cycle after acceptance. Commands stall whenever CKE is low, and also during the recovery window after self-refresh. That window is the larger of the row-cycle time and the self-refresh exit time, each a parameter in clock cycles. All pin outputs come straight from flops, so CKE changes a whole clock period before the edge at which the device samples it. This meets the CKE setup requirement.

Top module: `sdr_lowpwr_ctrl`

## Requirements
- R1: After reset, cke is 1, sd_cmd_n is 3'b111 (NOP, bits {ras_n,cas_n,we_n}), freeze is 0 and lp_mode is 0 (run).
- R2: A cycle with burst_active=1 and susp_req=1 drives cke low from the next cycle for exactly susp_len cycles (susp_len 0 counts as 1, so runs of 1, 2 or 3 are possible). freeze is 1 in exactly those cycles and lp_mode is 1.
- R3: susp_req while burst_active is 0 has no effect: cke, freeze and lp_mode stay at their run values.
- R4: pd_req with no burst lowers cke in the next cycle. lp_mode becomes 2 (active power-down) if any bank_open bit is set and 3 (precharge power-down) if none is. The state holds while pd_req stays high.
- R5: sr_req with no burst and bank_open all zero issues the auto-refresh code 3'b001 on sd_cmd_n in the same cycle that cke first reads 0. lp_mode is then 4. Self-refresh wins over a simultaneous pd_req.
- R6: sr_req while any bank is open does not enter self-refresh. The block enters power-down instead if pd_req is high, and otherwise stays in run.
- R7: While cke is low, apart from the entry cycle of R5, sd_cmd_n is NOP and up_ready is 0. up_ready is also 0 during self-refresh exit recovery.
- R8: Dropping sr_req raises cke in the next cycle with lp_mode 5. A waiting command first appears on sd_cmd_n exactly max(T_RC_CYC, T_SREX_CYC) cycles after the first cycle with cke high, and never earlier.
- R9: In run mode with no low-power entry taken, up_ready is 1 and an accepted up_cmd appears on sd_cmd_n in the next cycle for one cycle. Without up_valid the pins show NOP.
- R10: Dropping pd_req returns cke to 1 and lp_mode to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | NBANK | One bit per bank, 1 when a row is open |
| burst_active | input | 1 | Burst engine has a read or write burst in flight |
| susp_req | input | 1 | Request a clock suspension during the burst |
| susp_len | input | SUSP_W | Number of cycles to suspend (0 treated as 1) |
| pd_req | input | 1 | Level request for power-down |
| sr_req | input | 1 | Level request for self-refresh |
| up_valid | input | 1 | Upstream command valid |
| up_cmd | input | 3 | Upstream command code {ras_n,cas_n,we_n} |
| up_ready | output | 1 | Upstream command accepted this cycle |
| cke | output | 1 | SDRAM clock enable |
| sd_cmd_n | output | 3 | SDRAM command pins {ras_n,cas_n,we_n} |
| freeze | output | 1 | Burst engine must hold its position this cycle |
| lp_mode | output | 3 | Current state: 0 run, 1 suspend, 2 active PD, 3 precharge PD, 4 self-refresh, 5 exit recovery |

## Verification
The hardest condition to reach is the end of self-refresh recovery. Two independent countdowns must both have expired, and a command must already be waiting, before the first legal command slot can be observed. The bench holds up_valid high from the cycle sr_req drops and counts cycles until the first non-NOP code appears. This pins down the exact slot and rules out an early issue. Suspension runs of each length are launched with up_valid held high, so a stall failure would show up as a command leaking onto the pins.

// File: rtl/sdr_lp_pkg.sv
package sdr_lp_pkg;

    typedef enum logic [2:0] {
        MODE_RUN     = 3'd0,
        MODE_SUSP    = 3'd1,
        MODE_PD_ACT  = 3'd2,
        MODE_PD_PRE  = 3'd3,
        MODE_SREF    = 3'd4,
        MODE_SR_EXIT = 3'd5
    } lp_mode_e;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_SUSP,
        ENT_PD,
        ENT_SREF
    } entry_e;

    // command codes as {ras_n, cas_n, we_n}, chip select held active
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_AREF = 3'b001;

endpackage

// File: rtl/sdr_lp_countdown.sv
module sdr_lp_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // an expired timer stays expired until reloaded (recovery window, R8)
    p_expired_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

    // a load of a non-zero value always opens a window
    p_load_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/sdr_lp_entry_sel.sv
module sdr_lp_entry_sel
    import sdr_lp_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic             burst_active,
    input  logic             susp_req,
    input  logic             pd_req,
    input  logic             sr_req,
    input  logic [NBANK-1:0] bank_open,
    output entry_e           entry
);

    logic all_idle;
    assign all_idle = (bank_open == '0);

    always_comb begin
        entry = ENT_NONE;
        if (burst_active) begin
            // only a clock suspension may interrupt a running burst
            if (susp_req) begin
                entry = ENT_SUSP;
            end
        end else if (sr_req && all_idle) begin
            entry = ENT_SREF;
        end else if (pd_req) begin
            entry = ENT_PD;
        end
    end

endmodule

// File: rtl/sdr_lowpwr_ctrl.sv
module sdr_lowpwr_ctrl
    import sdr_lp_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int SUSP_W     = 2,
    parameter int T_RC_CYC   = 6,
    parameter int T_SREX_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBANK-1:0]  bank_open,
    input  logic              burst_active,
    input  logic              susp_req,
    input  logic [SUSP_W-1:0] susp_len,
    input  logic              pd_req,
    input  logic              sr_req,
    input  logic              up_valid,
    input  logic [2:0]        up_cmd,
    output logic              up_ready,
    output logic              cke,
    output logic [2:0]        sd_cmd_n,
    output logic              freeze,
    output logic [2:0]        lp_mode
);

    localparam int NTMR   = 2;
    localparam int REC_M  = (T_RC_CYC > T_SREX_CYC) ? T_RC_CYC : T_SREX_CYC;
    localparam int TW     = $clog2(REC_M + 1);

    typedef struct packed {
        lp_mode_e          mode;
        logic              cke;
        logic              freeze;
        logic [2:0]        cmd;
        logic [SUSP_W-1:0] run;
    } ctl_t;

    ctl_t   s_d, s_q;
    entry_e entry;
    logic   tmr_load;
    logic [NTMR-1:0] tmr_done;
    logic   run_like;

    sdr_lp_entry_sel #(.NBANK(NBANK)) u_sel (
        .burst_active (burst_active),
        .susp_req     (susp_req),
        .pd_req       (pd_req),
        .sr_req       (sr_req),
        .bank_open    (bank_open),
        .entry        (entry)
    );

    // one countdown per recovery constraint; both start at the exit edge
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam int TVAL = (g == 0) ? T_RC_CYC : T_SREX_CYC;
        sdr_lp_countdown #(.W(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tmr_load),
            .load_val (TW'(TVAL - 1)),
            .done     (tmr_done[g])
        );
    end

    assign run_like = (s_q.mode == MODE_RUN) ||
                      ((s_q.mode == MODE_SR_EXIT) && (&tmr_done));

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        tmr_load = 1'b0;
        up_ready = 1'b0;
        if (run_like) begin
            s_d.mode   = MODE_RUN;
            s_d.cke    = 1'b1;
            s_d.freeze = 1'b0;
            s_d.run    = '0;
            unique case (entry)
                ENT_SUSP: begin
                    s_d.mode   = MODE_SUSP;
                    s_d.cke    = 1'b0;
                    s_d.freeze = 1'b1;
                    s_d.run    = (susp_len == '0) ? SUSP_W'(1) : susp_len;
                end
                ENT_SREF: begin
                    s_d.mode = MODE_SREF;
                    s_d.cke  = 1'b0;
                    s_d.cmd  = CMD_AREF;
                end
                ENT_PD: begin
                    s_d.mode = (bank_open != '0) ? MODE_PD_ACT : MODE_PD_PRE;
                    s_d.cke  = 1'b0;
                end
                default: begin
                    up_ready = 1'b1;
                    if (up_valid) begin
                        s_d.cmd = up_cmd;
                    end
                end
            endcase
        end else begin
            unique case (s_q.mode)
                MODE_SUSP: begin
                    if (s_q.run <= SUSP_W'(1)) begin
                        s_d.mode   = MODE_RUN;
                        s_d.cke    = 1'b1;
                        s_d.freeze = 1'b0;
                        s_d.run    = '0;
                    end else begin
                        s_d.run = s_q.run - 1'b1;
                    end
                end
                MODE_PD_ACT, MODE_PD_PRE: begin
                    if (!pd_req) begin
                        s_d.mode = MODE_RUN;
                        s_d.cke  = 1'b1;
                    end
                end
                MODE_SREF: begin
                    if (!sr_req) begin
                        s_d.mode = MODE_SR_EXIT;
                        s_d.cke  = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
                MODE_SR_EXIT: begin
                    s_d.cke = 1'b1;
                end
                default: begin
                    s_d.mode   = MODE_RUN;
                    s_d.cke    = 1'b1;
                    s_d.freeze = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode   <= MODE_RUN;
            s_q.cke    <= 1'b1;
            s_q.freeze <= 1'b0;
            s_q.cmd    <= CMD_NOP;
            s_q.run    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cke      = s_q.cke;
    assign sd_cmd_n = s_q.cmd;
    assign freeze   = s_q.freeze;
    assign lp_mode  = s_q.mode;

    // ---------------- checks guarding the logic above ----------------

    // cycles since the self-refresh exit raised cke, saturating at REC_M
    logic [TW-1:0] exit_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_age_q <= TW'(REC_M);
        end else if (tmr_load) begin
            exit_age_q <= '0;
        end else if (exit_age_q < TW'(REC_M)) begin
            exit_age_q <= exit_age_q + 1'b1;
        end
    end

    p_exit_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sd_cmd_n != CMD_NOP) |-> (exit_age_q >= TW'(REC_M)));

    p_nop_while_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (sd_cmd_n == CMD_NOP));

    p_no_accept_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> cke);

    p_sref_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == 3'(MODE_SREF) && $past(lp_mode) != 3'(MODE_SREF))
            |-> ($past(bank_open) == '0 && sd_cmd_n == CMD_AREF && !cke));

    p_freeze_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (!cke && lp_mode == 3'(MODE_SUSP)));

    p_susp_needs_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |-> $past(burst_active));

    p_pd_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lp_mode == 3'(MODE_PD_ACT) || lp_mode == 3'(MODE_PD_PRE)) && !pd_req)
            |=> (cke && lp_mode == 3'(MODE_RUN)));

endmodule

// File: tb/sim_sdr_lowpwr_ctrl.sv
module sim_sdr_lowpwr_ctrl;

    localparam int NBANK = 4;
    localparam int REC   = 6;   // max of the default row-cycle and exit times

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NBANK-1:0] bank_open = '0;
    logic             burst_active = 1'b0;
    logic             susp_req = 1'b0;
    logic [1:0]       susp_len = 2'd0;
    logic             pd_req = 1'b0;
    logic             sr_req = 1'b0;
    logic             up_valid = 1'b0;
    logic [2:0]       up_cmd = 3'b111;
    logic             up_ready;
    logic             cke;
    logic [2:0]       sd_cmd_n;
    logic             freeze;
    logic [2:0]       lp_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    sdr_lowpwr_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_open    (bank_open),
        .burst_active (burst_active),
        .susp_req     (susp_req),
        .susp_len     (susp_len),
        .pd_req       (pd_req),
        .sr_req       (sr_req),
        .up_valid     (up_valid),
        .up_cmd       (up_cmd),
        .up_ready     (up_ready),
        .cke          (cke),
        .sd_cmd_n     (sd_cmd_n),
        .freeze       (freeze),
        .lp_mode      (lp_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    endtask

    task automatic t_reset();
        chk(cke == 1'b1, "R1 cke", int'(cke), 1);
        chk(sd_cmd_n == 3'b111, "R1 cmd", int'(sd_cmd_n), 7);
        chk(freeze == 1'b0, "R1 freeze", int'(freeze), 0);
        chk(lp_mode == 3'd0, "R1 mode", int'(lp_mode), 0);
    endtask

    task automatic t_passthru();
        up_valid = 1'b1;
        up_cmd   = 3'b101;
        chk(up_ready == 1'b1, "R9 ready", int'(up_ready), 1);
        step();
        chk(sd_cmd_n == 3'b101, "R9 issued", int'(sd_cmd_n), 5);
        up_valid = 1'b0;
        step();
        chk(sd_cmd_n == 3'b111, "R9 nop after", int'(sd_cmd_n), 7);
    endtask

    task automatic t_suspend(input int len);
        int low;
        int frz;
        int leak;
        int exp_len;
        exp_len = (len == 0) ? 1 : len;
        burst_active = 1'b1;
        susp_req     = 1'b1;
        susp_len     = 2'(len);
        up_valid     = 1'b1;
        up_cmd       = 3'b011;
        step();
        susp_req = 1'b0;
        chk(lp_mode == 3'd1, "R2 mode", int'(lp_mode), 1);
        low = 0; frz = 0; leak = 0;
        for (int i = 0; i < 8 && !cke; i++) begin
            low++;
            if (freeze) frz++;
            if (up_ready || sd_cmd_n != 3'b111) leak++;
            step();
        end
        chk(low == exp_len, "R2 cke low run", low, exp_len);
        chk(frz == exp_len, "R2 freeze run", frz, exp_len);
        chk(leak == 0, "R7 stall in suspend", leak, 0);
        chk(freeze == 1'b0, "R2 freeze end", int'(freeze), 0);
        up_valid     = 1'b0;
        burst_active = 1'b0;
        step();
    endtask

    task automatic t_susp_no_burst();
        burst_active = 1'b0;
        susp_req     = 1'b1;
        susp_len     = 2'd3;
        step();
        chk(cke == 1'b1 && freeze == 1'b0, "R3 cke/freeze", int'({cke, freeze}), 2);
        chk(lp_mode == 3'd0, "R3 mode", int'(lp_mode), 0);
        susp_req = 1'b0;
        step();
    endtask

    task automatic t_pd(input logic [NBANK-1:0] banks, input int exp_mode);
        bank_open = banks;
        pd_req    = 1'b1;
        step();
        chk(cke == 1'b0, "R4 cke low", int'(cke), 0);
        chk(lp_mode == 3'(exp_mode), "R4 pd kind", int'(lp_mode), exp_mode);
        up_valid = 1'b1;
        up_cmd   = 3'b011;
        step();
        step();
        chk(cke == 1'b0 && lp_mode == 3'(exp_mode), "R4 held", int'(lp_mode), exp_mode);
        chk(up_ready == 1'b0 && sd_cmd_n == 3'b111, "R7 stall in pd",
            int'(sd_cmd_n), 7);
        up_valid = 1'b0;
        pd_req   = 1'b0;
        step();
        chk(cke == 1'b1 && lp_mode == 3'd0, "R10 pd exit", int'(lp_mode), 0);
        bank_open = '0;
        step();
    endtask

    task automatic t_sref_open();
        bank_open = 4'b0100;
        sr_req    = 1'b1;
        step();
        chk(cke == 1'b1 && lp_mode == 3'd0, "R6 open stays run", int'(lp_mode), 0);
        pd_req = 1'b1;
        step();
        chk(lp_mode == 3'd2, "R6 falls to pd", int'(lp_mode), 2);
        pd_req = 1'b0;
        sr_req = 1'b0;
        step();
        bank_open = '0;
        step();
    endtask

    task automatic t_sref();
        int waitc;
        bank_open = '0;
        sr_req    = 1'b1;
        pd_req    = 1'b1;
        step();
        chk(sd_cmd_n == 3'b001 && cke == 1'b0, "R5 entry refresh", int'(sd_cmd_n), 1);
        chk(lp_mode == 3'd4, "R5 mode", int'(lp_mode), 4);
        pd_req = 1'b0;
        step();
        chk(sd_cmd_n == 3'b111 && cke == 1'b0, "R7 nop in sref", int'(sd_cmd_n), 7);
        step();
        sr_req   = 1'b0;
        up_valid = 1'b1;
        up_cmd   = 3'b011;
        step();
        chk(cke == 1'b1 && lp_mode == 3'd5, "R8 exit start", int'(lp_mode), 5);
        waitc = 0;
        for (int i = 0; i < 20 && sd_cmd_n == 3'b111; i++) begin
            step();
            waitc++;
        end
        chk(waitc == REC, "R8 recovery gap", waitc, REC);
        chk(sd_cmd_n == 3'b011, "R8 command issued", int'(sd_cmd_n), 3);
        up_valid = 1'b0;
        step();
        chk(lp_mode == 3'd0, "R8 back to run", int'(lp_mode), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_passthru();
        t_suspend(1);
        t_suspend(2);
        t_suspend(3);
        t_suspend(0);
        t_susp_no_burst();
        t_pd(4'b0010, 2);
        t_pd(4'b0000, 3);
        t_sref_open();
        t_sref();
        summary();
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

endmodule